// File: doc/BRIEF.md
# Downward Stack Call/Return Sequencer

This block runs the stack side of a small processor. It accepts one command at a time: push a word, pop a word, call a subroutine, return from a subroutine, or return from an interrupt. It carries each command out as a series of single-byte transfers on an 8-bit memory bus with a 16-bit address. The block owns the stack pointer. The stack starts at 8000h and grows toward lower addresses in steps of two bytes. Each 16-bit element is stored with its low byte at the lower address.

Commands arrive on a valid/ready handshake. `cmd_ready` is high only while the sequencer is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While ready is low, the sender must hold the command code and its operands steady. Results have no back-pressure. `done` pulses for one cycle when a command finishes. In that same cycle the instruction-pointer load and the status-word load strobe, when the command produces them. The popped word stays on `pop_data` until the next pop.

For a call, the caller's instruction pointer comes in on `ip_cur` and the target address comes in on `call_tgt`. Decode of the instruction stream happens outside this block, and so does storage of the bytes.

Top module: `stk_callret_seq`

## Requirements
- R1: After reset the stack pointer is 8000h, `cmd_ready` is 1, and `mem_rd`, `mem_wr`, `done`, `ip_load`, `sts_load` and `mem_io` are 0.
- R2: A push-type command (code 0 PUSH, or code 2 CALL) first lowers the stack pointer by 2. It then writes the element at the new stack pointer and at the address one above it.
- R3: Every element is little-endian. Bits 7:0 sit at the lower address and go out in the first transfer. Bits 15:8 sit at the address one above.
- R4: A pop (code 1 POP) reads the stack pointer address and then the address one above it. It raises the stack pointer by 2 and presents the word on `pop_data`.
- R5: CALL pushes `ip_cur` as the element. On completion it pulses `ip_load` with `ip_value` equal to `call_tgt`.
- R6: A return (code 3 RET) pops one element and pulses `ip_load` with that element on `ip_value`.
- R7: An interrupt return (code 4 IRET) pops two elements. The first (top) element goes to `ip_value`. The second goes to `sts_value`. `ip_load` and `sts_load` pulse together, and the stack pointer rises by 4.
- R8: Each byte transfer lasts exactly one cycle with one strobe high. `mem_rd` and `mem_wr` are never high together, and `mem_io` stays 0.
- R9: `done` is a one-cycle pulse. It is high in the 3rd cycle after the accepting edge for one-element commands, and in the 5th cycle for IRET. `ip_load` and `sts_load` are high only together with `done`.
- R10: `cmd_ready` falls in the cycle after a legal command is accepted. It stays low until `done`.
- R11: `pop_data` keeps the last popped word through commands other than POP.
- R12: The reserved codes 5 to 7 are accepted. They finish with `done` in the 1st cycle after acceptance, with no memory strobe and no change to the stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd | input | 3 | Command code (0 PUSH, 1 POP, 2 CALL, 3 RET, 4 IRET) |
| push_val | input | 16 | Word to push for PUSH |
| call_tgt | input | 16 | Subroutine address for CALL |
| ip_cur | input | 16 | Current instruction pointer, pushed by CALL |
| done | output | 1 | One-cycle completion pulse |
| pop_data | output | 16 | Word from the last POP |
| ip_load | output | 1 | Load instruction pointer |
| ip_value | output | 16 | New instruction pointer |
| sts_load | output | 1 | Load status word (IRET) |
| sts_value | output | 16 | Restored status word |
| stack_ptr | output | 16 | Current stack pointer |
| mem_addr | output | 16 | Memory address register |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid in the cycle `mem_rd` is high |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_io | output | 1 | Space select, 0 for memory |

## Verification
The bench aims at byte order and address order. A design that swapped the lanes, or wrote before lowering the pointer, would leave the bytes of an element reversed, or one element off from where later pops read. IRET is checked with two distinct words stacked, so returning the pair in push order shows up at once as exchanged IP and status values. Strobe counts and completion latency are measured per command, which catches a transfer held for two cycles or a second element skipped. Reserved codes and commands that are not pops are checked for a pointer, `pop_data` or IP load they should not have touched.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    CMD_PUSH = 3'd0,
    CMD_POP  = 3'd1,
    CMD_CALL = 3'd2,
    CMD_RET  = 3'd3,
    CMD_IRET = 3'd4
  } stk_cmd_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } stk_state_e;
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int AW = 16,
  parameter int STEP = 2,
  parameter logic [AW-1:0] SP_RST = 16'h8000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec,
  input  logic          inc,
  output logic [AW-1:0] sp
);
  localparam logic [AW-1:0] STEP_W = AW'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp <= SP_RST;
    else if (dec) sp <= sp - STEP_W;
    else if (inc) sp <= sp + STEP_W;
  end

  // R2/R4: the pointer never moves both ways in one cycle
  assert_no_incdec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec && inc));
endmodule

// File: rtl/stk_lane.sv
module stk_lane #(
  parameter int WW = 16,
  parameter int DW = 8,
  parameter int KW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WW-1:0] load_word,
  input  logic          cap,
  input  logic [KW-1:0] byte_k,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] wbyte,
  output logic [WW-1:0] cap_word
);
  logic [WW-1:0] out_q;
  logic [WW-1:0] in_q;

  // R3: byte k of a word is lane k, lane 0 at the lowest address
  always_comb begin
    wbyte = out_q[byte_k*DW +: DW];
    cap_word = in_q;
    cap_word[byte_k*DW +: DW] = rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      in_q  <= '0;
    end else begin
      if (load) out_q <= load_word;
      if (cap)  in_q  <= cap_word;
    end
  end
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int AW = 16,
  parameter int WW = 16,
  parameter int DW = 8,
  parameter int KW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd,
  input  logic [WW-1:0] push_val,
  input  logic [AW-1:0] call_tgt,
  input  logic [AW-1:0] ip_cur,
  input  logic [AW-1:0] sp,
  output logic          sp_dec,
  output logic          sp_inc,
  output logic          lane_load,
  output logic [WW-1:0] lane_word,
  output logic          lane_cap,
  output logic [KW-1:0] byte_k,
  input  logic [WW-1:0] cap_word,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          done,
  output logic          ip_load,
  output logic [AW-1:0] ip_value,
  output logic          sts_load,
  output logic [WW-1:0] sts_value,
  output logic [WW-1:0] pop_data
);
  localparam int BPW = WW / DW;
  localparam logic [AW-1:0] STEP_W = AW'(BPW);
  localparam logic [KW-1:0] LAST_K = KW'(BPW - 1);

  stk_state_e state;
  stk_cmd_e   cmd_q;
  logic [AW-1:0] tgt_q;
  logic          elem_k;
  logic accept, legal, wr_type, last_byte, more_elem;

  always_comb begin
    accept    = cmd_valid && (state == ST_IDLE);
    legal     = cmd <= 3'(CMD_IRET);
    wr_type   = (cmd == 3'(CMD_PUSH)) || (cmd == 3'(CMD_CALL));
    last_byte = byte_k == LAST_K;
    more_elem = (cmd_q == CMD_IRET) && !elem_k;
    cmd_ready = state == ST_IDLE;
    sp_dec    = accept && legal && wr_type;
    sp_inc    = (state == ST_XFER) && mem_rd && last_byte;
    lane_load = accept;
    lane_word = (cmd == 3'(CMD_CALL)) ? WW'(ip_cur) : push_val;
    lane_cap  = (state == ST_XFER) && mem_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  cmd_q <= CMD_PUSH;  tgt_q <= '0;
      byte_k <= '0;      elem_k <= 1'b0;     mem_addr <= '0;
      mem_rd <= 1'b0;    mem_wr <= 1'b0;     done <= 1'b0;
      ip_load <= 1'b0;   sts_load <= 1'b0;   ip_value <= '0;
      sts_value <= '0;   pop_data <= '0;
    end else begin
      done     <= 1'b0;
      ip_load  <= 1'b0;
      sts_load <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (!legal) begin
              done <= 1'b1;                       // R12
            end else begin
              cmd_q  <= stk_cmd_e'(cmd);
              tgt_q  <= call_tgt;
              byte_k <= '0;
              elem_k <= 1'b0;
              state  <= ST_XFER;
              if (wr_type) begin
                mem_addr <= sp - STEP_W;          // R2: lower first
                mem_wr   <= 1'b1;
              end else begin
                mem_addr <= sp;                   // R4
                mem_rd   <= 1'b1;
              end
            end
          end
        end
        ST_XFER: begin
          mem_addr <= mem_addr + 1'b1;
          if (!last_byte) begin
            byte_k <= byte_k + 1'b1;
          end else begin
            byte_k <= '0;
            if (more_elem) begin
              elem_k   <= 1'b1;                   // R7: IP first
              ip_value <= AW'(cap_word);
            end else begin
              state  <= ST_IDLE;
              mem_rd <= 1'b0;
              mem_wr <= 1'b0;
              done   <= 1'b1;
              case (cmd_q)
                CMD_POP:  pop_data <= cap_word;
                CMD_RET:  begin ip_value <= AW'(cap_word); ip_load <= 1'b1; end
                CMD_IRET: begin sts_value <= cap_word; ip_load <= 1'b1; sts_load <= 1'b1; end
                CMD_CALL: begin ip_value <= tgt_q; ip_load <= 1'b1; end
                default:  ;
              endcase
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_rdwr_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_ipld_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_load || sts_load) |-> done);
  assert_ready_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd <= 3'(CMD_IRET))) |=> !cmd_ready);
endmodule

// File: rtl/stk_callret_seq.sv
module stk_callret_seq #(
  parameter int AW = 16,
  parameter int WW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] SP_RST = 16'h8000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd,
  input  logic [WW-1:0] push_val,
  input  logic [AW-1:0] call_tgt,
  input  logic [AW-1:0] ip_cur,
  output logic          done,
  output logic [WW-1:0] pop_data,
  output logic          ip_load,
  output logic [AW-1:0] ip_value,
  output logic          sts_load,
  output logic [WW-1:0] sts_value,
  output logic [AW-1:0] stack_ptr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          mem_io
);
  localparam int BPW = WW / DW;
  localparam int KW  = (BPW > 1) ? $clog2(BPW) : 1;

  logic          sp_dec, sp_inc, lane_load, lane_cap;
  logic [WW-1:0] lane_word, cap_word;
  logic [KW-1:0] byte_k;

  assign mem_io = 1'b0;  // R8: memory space only

  stk_ptr #(.AW(AW), .STEP(BPW), .SP_RST(SP_RST)) u_ptr (
    .clk(clk), .rst_n(rst_n), .dec(sp_dec), .inc(sp_inc), .sp(stack_ptr));

  stk_lane #(.WW(WW), .DW(DW), .KW(KW)) u_lane (
    .clk(clk), .rst_n(rst_n), .load(lane_load), .load_word(lane_word),
    .cap(lane_cap), .byte_k(byte_k), .rdata(mem_rdata),
    .wbyte(mem_wdata), .cap_word(cap_word));

  stk_ctrl #(.AW(AW), .WW(WW), .DW(DW), .KW(KW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd(cmd), .push_val(push_val), .call_tgt(call_tgt), .ip_cur(ip_cur),
    .sp(stack_ptr), .sp_dec(sp_dec), .sp_inc(sp_inc), .lane_load(lane_load),
    .lane_word(lane_word), .lane_cap(lane_cap), .byte_k(byte_k),
    .cap_word(cap_word), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .done(done), .ip_load(ip_load), .ip_value(ip_value),
    .sts_load(sts_load), .sts_value(sts_value), .pop_data(pop_data));

  // R2/R4: an element's first byte sits at the current stack pointer
  assert_first_addr_sp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_wr) || $rose(mem_rd)) |-> (mem_addr == stack_ptr));
  // R3: the high byte follows at the next address
  assert_next_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_wr) || $rose(mem_rd)) |=> (mem_addr == AW'($past(mem_addr) + 1'b1)));
endmodule

// File: tb/test_stk_callret_seq.sv
`timescale 1ns/1ps
module test_stk_callret_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd = 3'd0;
  logic [15:0] push_val = '0, call_tgt = '0, ip_cur = '0;
  logic        done, ip_load, sts_load, mem_rd, mem_wr, mem_io;
  logic [15:0] pop_data, ip_value, sts_value, stack_ptr, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0]  mem [0:1023];
  logic [15:0] stk [0:255];
  int          depth = 0;
  logic [15:0] sp_exp = 16'h8000;
  logic [15:0] last_pop = 16'h0000;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  stk_callret_seq i_stk_callret_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd(cmd), .push_val(push_val), .call_tgt(call_tgt), .ip_cur(ip_cur),
    .done(done), .pop_data(pop_data), .ip_load(ip_load), .ip_value(ip_value),
    .sts_load(sts_load), .sts_value(sts_value), .stack_ptr(stack_ptr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_io(mem_io));

  assign mem_rdata = mem_rd ? mem[mem_addr[9:0]] : 8'h00;
  always @(posedge clk) if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [2:0] c);
    if (c > 3'd4) return 1;
    return (c == 3'd4) ? 5 : 3;
  endfunction

  function automatic int exp_reads(input logic [2:0] c);
    case (c)
      3'd1, 3'd3: return 2;
      3'd4:       return 4;
      default:    return 0;
    endcase
  endfunction

  function automatic int exp_writes(input logic [2:0] c);
    return (c == 3'd0 || c == 3'd2) ? 2 : 0;
  endfunction

  task automatic do_cmd(input logic [2:0] c, input logic [15:0] v, input logic [15:0] t, input logic [15:0] ipc);
    int n = 0, nrd = 0, nwr = 0, bad = 0;
    logic [15:0] e_ip, e_sts, e_pop, word;
    bit rdy1 = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; push_val = v; call_tgt = t; ip_cur = ipc;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    while (n < 20) begin
      @(negedge clk);
      n++;
      if (n == 1) rdy1 = cmd_ready;
      if (mem_rd) nrd++;
      if (mem_wr) nwr++;
      if ((mem_rd && mem_wr) || mem_io) bad++;
      if (done) break;
    end
    chk(n == exp_lat(c), "R9 done latency", n, exp_lat(c));
    chk(nrd == exp_reads(c) && nwr == exp_writes(c), "R8 strobe cycles",
        {nrd[15:0], nwr[15:0]}, {16'(exp_reads(c)), 16'(exp_writes(c))});
    chk(bad == 0, "R8 rd/wr overlap or io select", bad, 0);
    if (c <= 3'd4) chk(rdy1 == 1'b0, "R10 ready low while busy", rdy1, 0);
    e_ip = 16'h0; e_sts = 16'h0; e_pop = last_pop;
    case (c)
      3'd0, 3'd2: begin
        word = (c == 3'd2) ? ipc : v;
        sp_exp = sp_exp - 16'd2;
        stk[depth] = word; depth++;
        chk({mem[sp_exp[9:0] + 10'd1], mem[sp_exp[9:0]]} == word, "R3 little-endian bytes",
            {mem[sp_exp[9:0] + 10'd1], mem[sp_exp[9:0]]}, word);
        if (c == 3'd2) chk(ip_load && ip_value == t, "R5 call ip load", {15'd0, ip_load, ip_value}, {16'd1, t});
        else chk(!ip_load, "R9 no ip load on push", ip_load, 0);
      end
      3'd1, 3'd3: begin
        depth--; e_pop = stk[depth]; sp_exp = sp_exp + 16'd2;
        if (c == 3'd1) begin
          last_pop = e_pop;
          chk(pop_data == e_pop, "R4 pop data", pop_data, e_pop);
        end else begin
          chk(ip_load && ip_value == e_pop, "R6 ret ip load", {15'd0, ip_load, ip_value}, {16'd1, e_pop});
        end
      end
      3'd4: begin
        e_ip = stk[depth-1]; e_sts = stk[depth-2]; depth -= 2;
        sp_exp = sp_exp + 16'd4;
        chk(ip_load && sts_load && ip_value == e_ip && sts_value == e_sts, "R7 iret order",
            {ip_value, sts_value}, {e_ip, e_sts});
      end
      default: chk(!ip_load && !sts_load, "R12 reserved no load", {ip_load, sts_load}, 0);
    endcase
    if (c != 3'd4) chk(!sts_load, "R9 sts_load only on iret", sts_load, 0);
    if (c != 3'd1) chk(pop_data == last_pop, "R11 pop_data held", pop_data, last_pop);
    chk(stack_ptr == sp_exp, (c > 3'd4) ? "R12 sp unchanged" : "R2 R4 stack pointer", stack_ptr, sp_exp);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(stack_ptr == 16'h8000, "R1 reset sp", stack_ptr, 16'h8000);
    chk(cmd_ready && !mem_rd && !mem_wr && !done && !ip_load && !sts_load && !mem_io,
        "R1 reset outputs", {cmd_ready, mem_rd, mem_wr, done, ip_load, sts_load, mem_io}, 7'h40);
    rst_n = 1'b1;
    // directed corners
    do_cmd(3'd0, 16'h1234, 16'h0, 16'h0);         // R2/R3: 34h at 7FFEh
    chk(mem[10'h3FE] == 8'h34 && mem[10'h3FF] == 8'h12, "R3 first element at 7FFEh",
        {mem[10'h3FF], mem[10'h3FE]}, 16'h1234);
    do_cmd(3'd2, 16'h0, 16'h3000, 16'h2010);      // R5
    do_cmd(3'd3, 16'h0, 16'h0, 16'h0);            // R6 returns 2010h
    do_cmd(3'd5, 16'h0, 16'h0, 16'h0);            // R12
    do_cmd(3'd7, 16'h0, 16'h0, 16'h0);            // R12
    do_cmd(3'd0, 16'hA5F0, 16'h0, 16'h0);         // status-like word
    do_cmd(3'd2, 16'h0, 16'h4000, 16'h0BCD);      // ip word on top
    do_cmd(3'd4, 16'h0, 16'h0, 16'h0);            // R7: ip 0BCDh, status A5F0h
    do_cmd(3'd1, 16'h0, 16'h0, 16'h0);            // R4: back to 8000h
    chk(stack_ptr == 16'h8000, "R4 pointer restored", stack_ptr, 16'h8000);
    // constrained random mix
    for (int k = 0; k < 400; k++) begin
      int r;
      logic [2:0] c;
      r = int'($urandom % 100);
      if (r < 30) c = 3'd0;
      else if (r < 45) c = 3'd2;
      else if (r < 65) c = 3'd1;
      else if (r < 80) c = 3'd3;
      else if (r < 93) c = 3'd4;
      else c = 3'(5 + r % 3);
      if ((c == 3'd1 || c == 3'd3) && depth < 1) c = 3'd0;
      if (c == 3'd4 && depth < 2) c = 3'd2;
      if ((c == 3'd0 || c == 3'd2) && depth > 200) c = 3'd1;
      do_cmd(c, 16'($urandom), 16'($urandom), 16'($urandom));
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule